// File: doc/BRIEF.md
# Converter Power-Down and Port Mode Controller

This block is the mode-control core of a two-port (copper and fiber) media converter. It owns the power-down sequencing of the device. An active-low power-down pin holds all logic in reset. When the pin is released, a fixed settling interval is counted. At the end of that interval the strap pins for duplex, speed, output types, station address and backup-link enable are captured, and the device comes out of reset.

A small management register, the mode register at address 31, gives software control of the device. Software can power down the datapath without touching the management side, loop either port back on itself, take the clock/data PLL out of the loopback path, and force either output off. Active-low disable pins for each port are combined with the register bits to form the output enables. Those enables drive the tristate controls of the data outputs outside this block. The analog drivers, the PLL and the data paths are not part of this block.

The reset input `rst_n` is the chip power-on reset. It behaves exactly like a held power-down pin, so the straps are also captured once after power-on.

Top module: `phy_mode_ctrl`

## Requirements
- R1: While the power-down pin `pwrdn_n_i` is low (sampled through a two-stage synchronizer), `pd_rst_n_o`, both output enables, both loopback selects and `pll_bypass_o` are 0 from the third clock edge after the pin falls.
- R2: After `pwrdn_n_i` rises, the strap pins are captured on clock edge RELATCH_CYCLES+3 counted from the rise. `pd_rst_n_o` rises on that same edge. Strap values before or after that edge do not reach the `cfg_*_o` outputs.
- R3: A pin power-down returns the mode register to its default 0x0400 (bit 10 set, all else 0). Writes made while the pin is low or during the settling interval are ignored.
- R4: Mode register bit 15 set forces `pd_rst_n_o`, both output enables, both loopbacks and `pll_bypass_o` to 0. The register stays readable and writable, and the captured straps keep their values. Clearing bit 15 resumes operation at once, with no new strap capture.
- R5: Mode bit 12 set drives `cu_loop_o` high, and mode bit 11 set drives `fo_loop_o` high, while the device runs.
- R6: `pll_bypass_o` is 1 exactly when the device runs, at least one loopback is active, and mode bit 10 (active low) is 0.
- R7: `cu_oe_o` is 1 exactly when the device runs, `cu_off_n_i` is 1 and mode bit 13 is 0. `fo_oe_o` is 1 exactly when the device runs, `fo_off_n_i` is 1 and mode bit 14 is 0.
- R8: Reading address 31 returns mode bits 15..10 in place, with bits 9..0 reading 0. Any other address reads 0, and writes to it change nothing.
- R9: Chip reset `rst_n` low acts like a held power-down pin. Releasing it starts the same settling interval and strap capture as R2, and the captured strap outputs read 0 before the first capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low chip reset |
| pwrdn_n_i | input | 1 | Asynchronous active-low power-down pin |
| strap_duplex_i | input | 1 | Duplex strap pin |
| strap_speed_i | input | 1 | Speed strap pin |
| strap_cu_pecl_i | input | 1 | Copper output type strap pin |
| strap_fo_pecl_i | input | 1 | Fiber output type strap pin |
| strap_backup_i | input | 1 | Backup-link enable strap pin |
| strap_addr_i | input | 5 | Station address strap pins |
| cu_off_n_i | input | 1 | Active-low copper output disable pin |
| fo_off_n_i | input | 1 | Active-low fiber output disable pin |
| mgmt_addr_i | input | ADDR_W | Management register address |
| mgmt_wdata_i | input | 16 | Management write data |
| mgmt_we_i | input | 1 | Management write strobe |
| mgmt_rdata_o | output | 16 | Management read data (combinational from address) |
| cfg_duplex_o | output | 1 | Captured duplex strap |
| cfg_speed_o | output | 1 | Captured speed strap |
| cfg_cu_pecl_o | output | 1 | Captured copper output type |
| cfg_fo_pecl_o | output | 1 | Captured fiber output type |
| cfg_backup_o | output | 1 | Captured backup-link enable |
| cfg_addr_o | output | 5 | Captured station address |
| pd_rst_n_o | output | 1 | Active-low power-down/reset to the rest of the device |
| cu_loop_o | output | 1 | Copper loopback select |
| fo_loop_o | output | 1 | Fiber loopback select |
| pll_bypass_o | output | 1 | Remove the PLL from the loopback path |
| cu_oe_o | output | 1 | Copper output enable (0 puts the outputs in high impedance) |
| fo_oe_o | output | 1 | Fiber output enable (0 puts the outputs in high impedance) |

## Verification
The assertions check four relations on every cycle. Outputs are quiet whenever the device is held down. An output enable never asserts against a low disable pin. The PLL bypass only appears alongside a loopback. The reserved read bits stay zero. They also check that the captured straps change only on the edge where the device leaves reset. Only the bench's scenarios can show the exact edge count of the settling interval and which strap values get captured. The same holds for the difference between pin and register power-down: register defaults against kept contents, and a new capture against none. The bench also sweeps every combination of the six mode bits and both disable pins against arithmetically computed enables.

// File: rtl/phy_mode_pkg.sv
// Package: shared constants and types for the power-down and mode controller.
// Assumes the management data word is 16 bits wide, with mode fields fixed in
// the upper six bits of the mode register.
package phy_mode_pkg;

    localparam int REG_DATA_W = 16;
    localparam int STRAP_ADDR_W = 5;

    // Bit positions in the mode register (software-visible, so fixed).
    localparam int B_SOFT_PD   = 15;
    localparam int B_FO_OFF    = 14;
    localparam int B_CU_OFF    = 13;
    localparam int B_CU_LOOP   = 12;
    localparam int B_FO_LOOP   = 11;
    localparam int B_PLL_IN_N  = 10;
    localparam int MODE_LSB    = 10;
    localparam int MODE_W      = REG_DATA_W - MODE_LSB;

    // Default after a pin power-down: PLL kept in the loopback path.
    localparam logic [MODE_W-1:0] MODE_DEFAULT = MODE_W'(1);

    typedef struct packed {
        logic                    duplex;
        logic                    speed;
        logic                    cu_pecl;
        logic                    fo_pecl;
        logic                    backup;
        logic [STRAP_ADDR_W-1:0] addr;
    } strap_t;

    typedef enum logic [1:0] {
        SEQ_DOWN = 2'd0,
        SEQ_WAIT = 2'd1,
        SEQ_RUN  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/pd_sync.sv
// Module: pd_sync
// Brings the asynchronous power-down pin into the clock domain.
// Assumes STAGES >= 2. Reset forces the synchronized level low, which means powered down.
module pd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_q;

    // Shift the pin level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_i};
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/relatch_seq.sv
// Module: relatch_seq
// Power-down sequencer. It holds the device down while the pin is low, then
// counts RELATCH_CYCLES, then captures the strap pins and enters run.
// Assumes RELATCH_CYCLES >= 1 and that the strap pins are stable at the capture edge.
module relatch_seq
    import phy_mode_pkg::*;
#(
    parameter int RELATCH_CYCLES = 125
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   pin_up_i,
    input  strap_t strap_i,
    output strap_t strap_q_o,
    output logic   ready_o
);

    localparam int CNT_W = $clog2(RELATCH_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RELATCH_CYCLES - 1);

    seq_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             capture;

    assign capture = (state_q == SEQ_WAIT) && (cnt_q == CNT_LAST);

    // State and settling counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !pin_up_i) begin
            state_q <= SEQ_DOWN;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                SEQ_DOWN: begin
                    state_q <= SEQ_WAIT;
                    cnt_q   <= '0;
                end
                SEQ_WAIT: begin
                    if (capture) state_q <= SEQ_RUN;
                    else         cnt_q   <= cnt_q + 1'b1;
                end
                default: state_q <= SEQ_RUN;
            endcase
        end
    end

    // Strap capture register, updated only at the end of the settling interval.
    always_ff @(posedge clk) begin
        if (!rst_n)       strap_q_o <= '0;
        else if (capture) strap_q_o <= strap_i;
    end

    assign ready_o = (state_q == SEQ_RUN);

endmodule

// File: rtl/mode_regs.sv
// Module: mode_regs
// Holds the mode register and builds the read data.
// Assumes writes are honoured only while the sequencer reports ready. Outside that
// window the register is held at its default value.
module mode_regs
    import phy_mode_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int REG_ADDR = 31
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ready_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [REG_DATA_W-1:0] wdata_i,
    input  logic                  we_i,
    output logic [REG_DATA_W-1:0] rdata_o,
    output logic [MODE_W-1:0]     mode_o
);

    localparam logic [ADDR_W-1:0] SEL = ADDR_W'(REG_ADDR);

    logic hit;
    assign hit = (addr_i == SEL);

    // Mode register: held at default until ready, then written by software.
    always_ff @(posedge clk) begin
        if (!rst_n || !ready_i)  mode_o <= MODE_DEFAULT;
        else if (we_i && hit)    mode_o <= wdata_i[REG_DATA_W-1:MODE_LSB];
    end

    // Read mux: unused low bits and other addresses read 0.
    always_comb begin
        rdata_o = '0;
        if (hit) rdata_o = {mode_o, {MODE_LSB{1'b0}}};
    end

endmodule

// File: rtl/phy_mode_ctrl.sv
// Module: phy_mode_ctrl (top)
// Power-down and mode control for a copper/fiber media converter. It combines
// pin and register power-down, strap capture, loopback and PLL-bypass selects,
// and the output enables.
// Assumes the strap pins are static around the capture edge, and that the output
// enables drive tristate controls outside this block.
module phy_mode_ctrl
    import phy_mode_pkg::*;
#(
    parameter int RELATCH_CYCLES = 125,
    parameter int SYNC_STAGES    = 2,
    parameter int ADDR_W         = 5,
    parameter int REG_ADDR       = 31
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pwrdn_n_i,
    input  logic                    strap_duplex_i,
    input  logic                    strap_speed_i,
    input  logic                    strap_cu_pecl_i,
    input  logic                    strap_fo_pecl_i,
    input  logic                    strap_backup_i,
    input  logic [STRAP_ADDR_W-1:0] strap_addr_i,
    input  logic                    cu_off_n_i,
    input  logic                    fo_off_n_i,
    input  logic [ADDR_W-1:0]       mgmt_addr_i,
    input  logic [REG_DATA_W-1:0]   mgmt_wdata_i,
    input  logic                    mgmt_we_i,
    output logic [REG_DATA_W-1:0]   mgmt_rdata_o,
    output logic                    cfg_duplex_o,
    output logic                    cfg_speed_o,
    output logic                    cfg_cu_pecl_o,
    output logic                    cfg_fo_pecl_o,
    output logic                    cfg_backup_o,
    output logic [STRAP_ADDR_W-1:0] cfg_addr_o,
    output logic                    pd_rst_n_o,
    output logic                    cu_loop_o,
    output logic                    fo_loop_o,
    output logic                    pll_bypass_o,
    output logic                    cu_oe_o,
    output logic                    fo_oe_o
);

    logic              pin_up;
    logic              ready;
    logic              run;
    strap_t            strap_in;
    strap_t            strap_q;
    logic [MODE_W-1:0] mode;

    pd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pwrdn_n_i),
        .sync_o  (pin_up)
    );

    assign strap_in = '{duplex: strap_duplex_i, speed: strap_speed_i,
                        cu_pecl: strap_cu_pecl_i, fo_pecl: strap_fo_pecl_i,
                        backup: strap_backup_i, addr: strap_addr_i};

    relatch_seq #(.RELATCH_CYCLES(RELATCH_CYCLES)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_up_i  (pin_up),
        .strap_i   (strap_in),
        .strap_q_o (strap_q),
        .ready_o   (ready)
    );

    mode_regs #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .ready_i (ready),
        .addr_i  (mgmt_addr_i),
        .wdata_i (mgmt_wdata_i),
        .we_i    (mgmt_we_i),
        .rdata_o (mgmt_rdata_o),
        .mode_o  (mode)
    );

    // Running means sequenced up and not powered down by software.
    assign run = ready && !mode[B_SOFT_PD - MODE_LSB];

    // Output stage: loopback, PLL bypass and output enables gated by run.
    always_comb begin
        pd_rst_n_o   = run;
        cu_loop_o    = run && mode[B_CU_LOOP - MODE_LSB];
        fo_loop_o    = run && mode[B_FO_LOOP - MODE_LSB];
        pll_bypass_o = (cu_loop_o || fo_loop_o) && !mode[B_PLL_IN_N - MODE_LSB];
        cu_oe_o      = run && cu_off_n_i && !mode[B_CU_OFF - MODE_LSB];
        fo_oe_o      = run && fo_off_n_i && !mode[B_FO_OFF - MODE_LSB];
    end

    assign cfg_duplex_o  = strap_q.duplex;
    assign cfg_speed_o   = strap_q.speed;
    assign cfg_cu_pecl_o = strap_q.cu_pecl;
    assign cfg_fo_pecl_o = strap_q.fo_pecl;
    assign cfg_backup_o  = strap_q.backup;
    assign cfg_addr_o    = strap_q.addr;

endmodule

// File: rtl/phy_mode_ctrl_chk.sv
// Module: phy_mode_ctrl_chk
// Cycle-by-cycle checks on the ports of phy_mode_ctrl, attached by bind.
// Assumes it only observes the block and drives nothing.
module phy_mode_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        pd_rst_n_o,
    input logic        cu_oe_o,
    input logic        fo_oe_o,
    input logic        cu_loop_o,
    input logic        fo_loop_o,
    input logic        pll_bypass_o,
    input logic        cu_off_n_i,
    input logic        fo_off_n_i,
    input logic [15:0] mgmt_rdata_o,
    input logic [9:0]  cfg_vec
);

    // R1
    quiet_when_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_rst_n_o |-> !(cu_oe_o || fo_oe_o || cu_loop_o || fo_loop_o || pll_bypass_o));

    // R7
    cu_pin_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cu_off_n_i |-> !cu_oe_o);

    // R7
    fo_pin_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fo_off_n_i |-> !fo_oe_o);

    // R6
    bypass_needs_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pll_bypass_o |-> (cu_loop_o || fo_loop_o));

    // R8
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_rdata_o[9:0] == 10'd0);

    // R2
    strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_vec) |-> $rose(pd_rst_n_o));

endmodule

bind phy_mode_ctrl phy_mode_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pd_rst_n_o   (pd_rst_n_o),
    .cu_oe_o      (cu_oe_o),
    .fo_oe_o      (fo_oe_o),
    .cu_loop_o    (cu_loop_o),
    .fo_loop_o    (fo_loop_o),
    .pll_bypass_o (pll_bypass_o),
    .cu_off_n_i   (cu_off_n_i),
    .fo_off_n_i   (fo_off_n_i),
    .mgmt_rdata_o (mgmt_rdata_o),
    .cfg_vec      ({cfg_duplex_o, cfg_speed_o, cfg_cu_pecl_o, cfg_fo_pecl_o,
                    cfg_backup_o, cfg_addr_o})
);

// File: tb/phy_mode_ctrl_tb.sv
// Bench for phy_mode_ctrl: strap capture timing, pin versus register power-down,
// and a full sweep of mode bits and disable pins.
module phy_mode_ctrl_tb;

    localparam int N = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwrdn_n = 1'b1;
    logic [9:0]  strap = '0;
    logic        cu_off_n = 1'b1;
    logic        fo_off_n = 1'b1;
    logic [4:0]  maddr = 5'd31;
    logic [15:0] mwdata = '0;
    logic        mwe = 1'b0;
    logic [15:0] mrdata;
    logic        c_dup, c_spd, c_cu, c_fo, c_bk;
    logic [4:0]  c_addr;
    logic        pd_rst_n, cu_loop, fo_loop, byp, cu_oe, fo_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    phy_mode_ctrl #(.RELATCH_CYCLES(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .pwrdn_n_i(pwrdn_n),
        .strap_duplex_i(strap[9]), .strap_speed_i(strap[8]),
        .strap_cu_pecl_i(strap[7]), .strap_fo_pecl_i(strap[6]),
        .strap_backup_i(strap[5]), .strap_addr_i(strap[4:0]),
        .cu_off_n_i(cu_off_n), .fo_off_n_i(fo_off_n),
        .mgmt_addr_i(maddr), .mgmt_wdata_i(mwdata), .mgmt_we_i(mwe),
        .mgmt_rdata_o(mrdata),
        .cfg_duplex_o(c_dup), .cfg_speed_o(c_spd), .cfg_cu_pecl_o(c_cu),
        .cfg_fo_pecl_o(c_fo), .cfg_backup_o(c_bk), .cfg_addr_o(c_addr),
        .pd_rst_n_o(pd_rst_n), .cu_loop_o(cu_loop), .fo_loop_o(fo_loop),
        .pll_bypass_o(byp), .cu_oe_o(cu_oe), .fo_oe_o(fo_oe)
    );

    function automatic logic [9:0] cfg_now();
        return {c_dup, c_spd, c_cu, c_fo, c_bk, c_addr};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        maddr = a; mwdata = d; mwe = 1'b1;
        @(negedge clk);
        mwe = 1'b0; maddr = 5'd31;
    endtask

    function automatic logic [5:0] outs_now();
        return {pd_rst_n, cu_loop, fo_loop, byp, cu_oe, fo_oe};
    endfunction

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [9:0] pat;
        logic [9:0] keep;
        logic       r;
        strap = 10'h2A5;
        ticks(3);
        // R9: reset state
        chk("R9 outputs in reset", {26'd0, outs_now()}, 32'd0);
        chk("R9 straps zero", {22'd0, cfg_now()}, 32'd0);
        chk("R9 read in reset", {16'd0, mrdata}, 32'h0400);

        // R9/R2: release reset, capture on edge N+3
        rst_n = 1'b1;
        ticks(N + 2);
        chk("R9 still down at N+2", {31'd0, pd_rst_n}, 32'd0);
        chk("R9 straps not yet captured", {22'd0, cfg_now()}, 32'd0);
        ticks(1);
        chk("R9 up at N+3", {31'd0, pd_rst_n}, 32'd1);
        chk("R9 straps captured", {22'd0, cfg_now()}, {22'd0, 10'h2A5});

        // R2/R3: pin power-down sweep over strap patterns
        for (int p = 0; p < 16; p++) begin
            pat = {p[3:0], p[0] ^ p[3], 5'((p * 7 + 3) % 32)};
            wr(5'd31, 16'h3800);
            pwrdn_n = 1'b0;
            ticks(4);
            chk("R1 pin down outputs quiet", {26'd0, outs_now()}, 32'd0);
            chk("R3 register defaulted", {16'd0, mrdata}, 32'h0400);
            wr(5'd31, 16'h3000);
            chk("R3 write while down ignored", {16'd0, mrdata}, 32'h0400);
            strap = ~pat;
            pwrdn_n = 1'b1;
            ticks(5);
            wr(5'd31, 16'h1000);
            chk("R3 write while settling ignored", {16'd0, mrdata}, 32'h0400);
            ticks(N - 6);
            strap = pat;
            ticks(2);
            chk("R2 down before capture edge", {31'd0, pd_rst_n}, 32'd0);
            ticks(1);
            strap = ~pat;
            chk("R2 up on capture edge", {31'd0, pd_rst_n}, 32'd1);
            ticks(2);
            chk("R2 captured value", {22'd0, cfg_now()}, {22'd0, pat});
        end

        // R4..R8: sweep all mode bit combinations and disable pins
        keep = cfg_now();
        for (int v = 0; v < 64; v++) begin
            for (int o = 0; o < 4; o++) begin
                cu_off_n = o[0]; fo_off_n = o[1];
                wr(5'd31, {v[5:0], 10'h3FF});
                r = ~v[5];
                chk("R8 readback", {16'd0, mrdata}, {16'd0, v[5:0], 10'd0});
                chk("R4 run flag", {31'd0, pd_rst_n}, {31'd0, r});
                chk("R5 loopbacks", {30'd0, cu_loop, fo_loop}, {30'd0, r & v[2], r & v[1]});
                chk("R6 pll bypass", {31'd0, byp}, {31'd0, r & (v[2] | v[1]) & ~v[0]});
                chk("R7 enables", {30'd0, cu_oe, fo_oe},
                    {30'd0, r & o[0] & ~v[3], r & o[1] & ~v[4]});
                chk("R4 straps kept", {22'd0, cfg_now()}, {22'd0, keep});
            end
        end
        cu_off_n = 1'b1; fo_off_n = 1'b1;

        // R4: leave soft power-down, no new capture
        strap = ~keep;
        wr(5'd31, 16'h0400);
        chk("R4 resume at once", {26'd0, outs_now()}, {26'd0, 6'b100011});
        ticks(N + 5);
        chk("R4 no recapture", {22'd0, cfg_now()}, {22'd0, keep});

        // R8: other addresses
        wr(5'd7, 16'hFFFF);
        maddr = 5'd7;
        @(negedge clk);
        chk("R8 other address reads 0", {16'd0, mrdata}, 32'd0);
        maddr = 5'd31;
        @(negedge clk);
        chk("R8 write elsewhere ignored", {16'd0, mrdata}, 32'h0400);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule